// File: doc/BRIEF.md
# UART Receive Gap Timeout Timer

This block sits next to a UART receiver and transmitter and watches the serial line for silence. Each received stop bit loads a counter. If no new character begins before a programmed number of clock cycles has passed, the block raises a one-cycle gap timeout event. Receive logic uses this event to flush a partly filled buffer or to mark the end of a message.

A 32-bit control word holds an enable bit and a timeout count. Two sticky status flags report when each direction goes from busy to quiet. The receive-side flag sets together with the gap timeout. The transmit-side flag sets when the transmit FIFO has drained and the shifter has stopped, after a period of activity. Software reads the flags and clears each one by writing 1 to its bit. The line-side inputs are single-cycle strobes (stop bit seen, start bit seen), plus level indications of FIFO-empty and shifter-busy.

Top module: `uart_gap_timer`

## Requirements
- R1: The control word has the enable at bit 31 and the timeout count N in bits 23:0. Bits 30:24 always read as 0. After reset the control word reads 0, the status reads 0, and no timeout is signalled.
- R2: While the enable bit is 0, stop-bit strobes start no count and no timeout is ever produced.
- R3: With the block enabled, `gap_timeout` goes high exactly N+1 clock cycles after the cycle in which `rx_stop_bit` is high. A new stop bit that arrives while a count is running restarts the count from zero.
- R4: `gap_timeout` is high for exactly one cycle and fires at most once per stop bit.
- R5: With N = 2559, the timeout appears 2560 cycles after the stop bit. This is a 10-bit gap at 115200 bit/s with a 29.4912 MHz clock.
- R6: A start-bit strobe that arrives while a count is running cancels that count without a timeout. The next stop bit counts again from zero.
- R7: Writing the enable to 0 stops and clears a running count. Enabling again does not resume the old count.
- R8: Status bit 0 (receive idle) becomes 1 on the same cycle that `gap_timeout` goes high.
- R9: Writing the status with a bit at 1 clears that flag. A bit at 0 leaves the flag unchanged. Bit 0 is receive idle and bit 1 is transmit idle.
- R10: When a flag's set condition and a write-1-to-clear of that flag land in the same cycle, the flag ends up 1.
- R11: The transmitter is active when `tx_fifo_empty` is 0 or `tx_shift_busy` is 1. Status bit 1 sets on the clock edge where the transmitter goes from active to idle, and never while it stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| sts_wr_en | input | 1 | Write strobe for the status (write 1 to clear) |
| sts_wdata | input | 2 | Status clear mask |
| sts_rdata | output | 2 | Status flags: bit 0 receive idle, bit 1 transmit idle |
| rx_stop_bit | input | 1 | Strobe: receiver sampled a stop bit |
| rx_start_bit | input | 1 | Strobe: receiver detected a start bit |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| tx_shift_busy | input | 1 | Transmit shifter is sending data |
| gap_timeout | output | 1 | One-cycle gap timeout event |

## Verification
The counting path is swept over every count from 0 to 9 and then run at the real-world count of 2559. Each run measures the exact cycle of the pulse and confirms there is only one, which separates an off-by-one load or compare from a correct one. Further runs cover a second stop bit arriving mid-count, a start bit arriving mid-count, and the enable being cleared mid-count or held low; these tell a restart apart from a cancel or a freeze. The flags are exercised with a clear that lands on the set cycle, with partial and zero-valued clear masks, and with the transmitter going idle both after shifter activity and after FIFO activity.

// File: rtl/uart_gap_pkg.sv
package uart_gap_pkg;
  localparam int WORD_W      = 32;
  localparam int EN_BIT      = 31;
  localparam int NUM_FLAGS   = 2;
  localparam int RX_IDLE_IDX = 0;
  localparam int TX_IDLE_IDX = 1;
endpackage

// File: rtl/gap_ctrl_reg.sv
module gap_ctrl_reg
  import uart_gap_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wdata,
  output logic                enable,
  output logic [CNT_W-1:0]    value,
  output logic [WORD_W-1:0]   rdata
);
  logic unused_rsvd;
  assign unused_rsvd = ^wdata[EN_BIT-1:CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      value  <= '0;
    end else if (wr_en) begin
      enable <= wdata[EN_BIT];
      value  <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata              = '0;
    rdata[EN_BIT]      = enable;
    rdata[CNT_W-1:0]   = value;
  end
endmodule

// File: rtl/gap_counter.sv
module gap_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] limit,
  input  logic             stop_seen,
  input  logic             start_seen,
  output logic             expire,
  output logic             timeout
);
  logic             running;
  logic [CNT_W-1:0] count;

  // Fires when the running count reaches the programmed limit this cycle.
  assign expire = enable && running && !stop_seen && !start_seen && (count == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      count   <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= expire;
      if (!enable) begin
        running <= 1'b0;
        count   <= '0;
      end else if (stop_seen) begin
        running <= 1'b1;
        count   <= '0;
      end else if (start_seen || expire) begin
        running <= 1'b0;
        count   <= '0;
      end else if (running) begin
        count   <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_idle_detect.sv
module tx_idle_detect (
  input  logic clk,
  input  logic rst,
  input  logic fifo_empty,
  input  logic shift_busy,
  output logic went_idle
);
  logic active_now;
  logic active_q;

  assign active_now = !fifo_empty || shift_busy;
  assign went_idle  = active_q && !active_now;

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= active_now;
  end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/uart_gap_timer.sv
module uart_gap_timer
  import uart_gap_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr_en,
  input  logic [WORD_W-1:0]    cfg_wdata,
  output logic [WORD_W-1:0]    cfg_rdata,
  input  logic                 sts_wr_en,
  input  logic [NUM_FLAGS-1:0] sts_wdata,
  output logic [NUM_FLAGS-1:0] sts_rdata,
  input  logic                 rx_stop_bit,
  input  logic                 rx_start_bit,
  input  logic                 tx_fifo_empty,
  input  logic                 tx_shift_busy,
  output logic                 gap_timeout
);
  logic             enable;
  logic [CNT_W-1:0] limit;
  logic             rx_expire;
  logic             tx_went_idle;
  logic [NUM_FLAGS-1:0] flag_set;

  gap_ctrl_reg #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wdata(cfg_wdata),
    .enable(enable), .value(limit), .rdata(cfg_rdata)
  );

  gap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .enable(enable), .limit(limit),
    .stop_seen(rx_stop_bit), .start_seen(rx_start_bit),
    .expire(rx_expire), .timeout(gap_timeout)
  );

  tx_idle_detect u_txd (
    .clk(clk), .rst(rst), .fifo_empty(tx_fifo_empty),
    .shift_busy(tx_shift_busy), .went_idle(tx_went_idle)
  );

  always_comb begin
    flag_set              = '0;
    flag_set[RX_IDLE_IDX] = rx_expire;
    flag_set[TX_IDLE_IDX] = tx_went_idle;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    sticky_flag u_flag (
      .clk(clk), .rst(rst), .set(flag_set[i]),
      .clr(sts_wr_en && sts_wdata[i]), .q(sts_rdata[i])
    );
  end
endmodule

// File: rtl/uart_gap_timer_chk.sv
module uart_gap_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cfg_rdata,
  input logic        sts_wr_en,
  input logic [1:0]  sts_wdata,
  input logic [1:0]  sts_rdata,
  input logic        rx_stop_bit,
  input logic        rx_start_bit,
  input logic        gap_timeout
);
  p_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    gap_timeout |=> !gap_timeout);

  p_flag_with_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    gap_timeout |-> sts_rdata[0]);

  p_rx_flag_source_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_rdata[0]) |-> gap_timeout);

  p_off_silent_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[31] |=> !gap_timeout);

  p_start_cancels_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_start_bit && !rx_stop_bit) |=> !gap_timeout);

  p_rx_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (sts_wr_en && sts_wdata[0]) |=> (!sts_rdata[0] || gap_timeout));

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[30:24] == 7'd0);
endmodule

bind uart_gap_timer uart_gap_timer_chk u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .sts_wr_en(sts_wr_en),
  .sts_wdata(sts_wdata), .sts_rdata(sts_rdata), .rx_stop_bit(rx_stop_bit),
  .rx_start_bit(rx_start_bit), .gap_timeout(gap_timeout)
);

// File: tb/tb_uart_gap_timer.sv
`timescale 1ns/1ps
module tb_uart_gap_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sts_wr_en = 1'b0;
  logic [1:0]  sts_wdata = '0;
  logic [1:0]  sts_rdata;
  logic        rx_stop_bit = 1'b0;
  logic        rx_start_bit = 1'b0;
  logic        tx_fifo_empty = 1'b1;
  logic        tx_shift_busy = 1'b0;
  logic        gap_timeout;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_gap_timer dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sts_wr_en(sts_wr_en), .sts_wdata(sts_wdata),
    .sts_rdata(sts_rdata), .rx_stop_bit(rx_stop_bit), .rx_start_bit(rx_start_bit),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_busy(tx_shift_busy),
    .gap_timeout(gap_timeout)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic wr_sts(input logic [1:0] d);
    @(negedge clk); sts_wr_en = 1'b1; sts_wdata = d;
    @(negedge clk); sts_wr_en = 1'b0;
  endtask

  task automatic stop_pulse();
    @(negedge clk); rx_stop_bit = 1'b1;
    @(negedge clk); rx_stop_bit = 1'b0;
  endtask

  // Counts negedges after a stop pulse; records first pulse and total pulses.
  task automatic watch(input int limit, output int first, output int hits, output int flag_miss);
    first = -1; hits = 0; flag_miss = 0;
    for (int m = 1; m <= limit; m++) begin
      @(negedge clk);
      if (gap_timeout) begin
        hits++;
        if (first < 0) first = m;
        if (!sts_rdata[0]) flag_miss++;
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int first, hits, miss;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 32'd0, "R1 reset ctrl", cfg_rdata, 0);
    chk(sts_rdata == 2'd0, "R1 reset status", sts_rdata, 0);
    chk(gap_timeout == 1'b0, "R1 reset timeout", gap_timeout, 0);

    wr_cfg(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h80FF_FFFF, "R1 layout/reserved", cfg_rdata, 32'h80FF_FFFF);

    // R3 R4 R8: sweep small counts
    for (int n = 0; n < 10; n++) begin
      wr_cfg(32'h8000_0000 | n);
      wr_sts(2'b11);
      stop_pulse();
      watch(2 * n + 12, first, hits, miss);
      chk(first == n + 1, "R3 pulse delay", first, n + 1);
      chk(hits == 1, "R4 single pulse", hits, 1);
      chk(miss == 0, "R8 rx idle with pulse", miss, 0);
    end

    // R5: real-world count
    wr_cfg(32'h8000_0000 | 2559);
    stop_pulse();
    watch(2600, first, hits, miss);
    chk(first == 2560, "R5 2559 delay", first, 2560);
    chk(hits == 1, "R5 single pulse", hits, 1);

    // R3: restart by second stop bit
    wr_cfg(32'h8000_0000 | 15);
    stop_pulse();
    watch(4, first, hits, miss);
    chk(hits == 0, "R3 no early pulse", hits, 0);
    stop_pulse();
    watch(40, first, hits, miss);
    chk(first == 16, "R3 restart delay", first, 16);

    // R6: start bit cancels
    wr_cfg(32'h8000_0000 | 20);
    stop_pulse();
    watch(10, first, hits, miss);
    @(negedge clk); rx_start_bit = 1'b1;
    @(negedge clk); rx_start_bit = 1'b0;
    watch(40, first, hits, miss);
    chk(hits == 0, "R6 cancelled", hits, 0);
    stop_pulse();
    watch(40, first, hits, miss);
    chk(first == 21, "R6 fresh count", first, 21);

    // R2: disabled
    wr_cfg(32'd3);
    stop_pulse();
    watch(20, first, hits, miss);
    chk(hits == 0, "R2 disabled silent", hits, 0);

    // R7: disable mid-count then re-enable
    wr_cfg(32'h8000_0000 | 10);
    stop_pulse();
    watch(4, first, hits, miss);
    wr_cfg(32'd10);
    wr_cfg(32'h8000_0000 | 10);
    watch(30, first, hits, miss);
    chk(hits == 0, "R7 count dropped", hits, 0);

    // R10: clear on the set cycle
    wr_cfg(32'h8000_0000 | 6);
    wr_sts(2'b11);
    stop_pulse();
    repeat (6) @(negedge clk);
    sts_wr_en = 1'b1; sts_wdata = 2'b01;
    @(negedge clk); sts_wr_en = 1'b0;
    chk(gap_timeout == 1'b1, "R10 pulse present", gap_timeout, 1);
    chk(sts_rdata[0] == 1'b1, "R10 set wins", sts_rdata[0], 1);

    // R9: clear masks
    wr_sts(2'b10);
    chk(sts_rdata[0] == 1'b1, "R9 other bit kept", sts_rdata[0], 1);
    wr_sts(2'b00);
    chk(sts_rdata[0] == 1'b1, "R9 zero keeps", sts_rdata[0], 1);
    wr_sts(2'b01);
    chk(sts_rdata[0] == 1'b0, "R9 one clears", sts_rdata[0], 0);

    // R11: transmitter idle after shifter activity
    chk(sts_rdata[1] == 1'b0, "R11 idle no set", sts_rdata[1], 0);
    @(negedge clk); tx_shift_busy = 1'b1;
    @(negedge clk); tx_shift_busy = 1'b0;
    @(negedge clk);
    chk(sts_rdata[1] == 1'b1, "R11 shifter done", sts_rdata[1], 1);
    wr_sts(2'b10);
    chk(sts_rdata[1] == 1'b0, "R9 tx clear", sts_rdata[1], 0);
    @(negedge clk); tx_fifo_empty = 1'b0;
    repeat (3) @(negedge clk);
    chk(sts_rdata[1] == 1'b0, "R11 active no set", sts_rdata[1], 0);
    tx_fifo_empty = 1'b1;
    @(negedge clk);
    chk(sts_rdata[1] == 1'b1, "R11 fifo drained", sts_rdata[1], 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule